// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Indirect Register Access

This block is a small set-associative translation lookaside buffer. Each entry holds a virtual page number, a process identifier, a physical frame number and five permission flags. Software never addresses an entry directly. It works through three control registers: a page-address register, a control register and an access register. The page-address register holds a page number. The control register holds a read strobe, a write enable, a way number and the current process identifier. The access register holds a frame number and its flags.

To read an entry, software selects a line by writing a page number whose low bits index that line. It then writes the control register with the read strobe set and a way number. The entry's contents come back into the three registers on the next clock. To write an entry, software sets write enable in the control register and then writes the access register. The entry at the current line and way is replaced, and the way number steps forward, so that consecutive access writes fill consecutive ways.

A separate combinational lookup port takes a virtual address and checks it against the indexed line, using the identifier held in the control register. It reports hit or miss, the winning way, and that way's frame and flags. The way count must be a power of two and at least two. The line count must be a power of two.

Top module: `sa_tlb`

## Requirements
- R1: After reset every entry holds an unmatchable page number with zero identifier, frame and flags. All three registers read zero, and no lookup hits.
- R2: A write with select 0 stores write-data bits [21:2] as the page number. The page-address register reads that page number at bits [21:2] and zero in all other bits.
- R3: A write with select 1 whose bit 0 is clear stores bit 1 as write enable, bits [4+WAY_W-1:4] as the way and bits [23:16] as the identifier. The control register reads those fields at the same positions, and every other bit, including bit 0, reads zero.
- R4: A write with select 1 whose bit 0 is set takes write enable and way from the written word. It loads the entry at (line = page-number low bits, that way): the entry's page number goes to the page-address register, its identifier to the control identifier field, and its frame and flags to the access register.
- R5: A write with select 2 stores bits [19:0] as the frame and bits [24:20] as flags (bit 20 cacheable, 21 read, 22 write, 23 execute, 24 global). The access register reads those bits and zero elsewhere. When write enable is set, the entry at (line, way) is replaced with the register page number, the control identifier and the written frame and flags.
- R6: After an access write with write enable set, the way field advances by one and wraps from WAYS-1 to 0. With write enable clear, the way field stays the same and no entry changes.
- R7: A lookup with address bits [31:12] as page number hits when the line given by the page-number low bits holds a way with the same page number and with either an equal identifier or the global flag. On a hit the block outputs that way, its frame and its flags. A page number that matches no way misses.
- R8: A matching page whose identifier differs from the current one and whose global flag is clear does not hit.
- R9: When several ways of a line match, the lowest-numbered way is reported.
- R10: A lookup page number whose top two bits are both set never hits. Writing such a page number with an all-zero access word therefore removes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wen | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 page address, 1 control, 2 access |
| reg_wdata | input | 32 | Register write data |
| lk_vaddr | input | 32 | Lookup virtual address |
| addr_q | output | 32 | Page-address register contents |
| misc_q | output | 32 | Control register contents |
| acc_q | output | 32 | Access register contents |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way that hit |
| lk_pfn | output | 20 | Frame number of the hitting way |
| lk_flags | output | 5 | Flags of the hitting way |

## Verification
The hardest state to reach is a line in which two ways hold the same page number. Normal auto-advancing fills never produce one. The stimulus builds it deliberately: it writes the higher way first, then points the way field back at the lower way and writes the same page again. This shows that the lowest way wins regardless of write order. It then removes the ways one at a time with the unmatchable page number and checks that the surviving way takes over, and that the unmatchable page number itself, although now stored with a matching identifier, still misses.

// File: rtl/sa_tlb_pkg.sv
package sa_tlb_pkg;
  localparam int VPN_W      = 20;
  localparam int PFN_W      = 20;
  localparam int PID_W      = 8;
  localparam int FLAG_N     = 5;
  localparam int REG_W      = 32;
  localparam int PG_SHIFT   = 12;
  localparam int ADR_VPN_LSB = 2;
  localparam int MSC_RD      = 0;
  localparam int MSC_WE      = 1;
  localparam int MSC_WAY_LSB = 4;
  localparam int MSC_PID_LSB = 16;
  localparam int ACC_FLG_LSB = PFN_W;
  localparam int FL_CACHE  = 0;
  localparam int FL_READ   = 1;
  localparam int FL_WRITE  = 2;
  localparam int FL_EXEC   = 3;
  localparam int FL_GLOBAL = 4;
  localparam logic [1:0] VOID_TOP = 2'b11;
  localparam logic [VPN_W-1:0] VOID_BASE = {VOID_TOP, {(VPN_W-2){1'b0}}};

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MISC = 2'd1,
    SEL_ACC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PID_W-1:0]  pid;
    logic [PFN_W-1:0]  pfn;
    logic [FLAG_N-1:0] flg;
  } tlb_ent_t;

  function automatic logic vpn_void(input logic [VPN_W-1:0] v);
    return v[VPN_W-1 -: 2] == VOID_TOP;
  endfunction
endpackage

// File: rtl/sa_tlb_store.sv
module sa_tlb_store
  import sa_tlb_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_line,
  input  logic [WAY_W-1:0]       wr_way,
  input  tlb_ent_t               wr_ent,
  input  logic [IDX_W-1:0]       rd_line,
  input  logic [WAY_W-1:0]       rd_way,
  output tlb_ent_t               rd_ent,
  input  logic [IDX_W-1:0]       lk_line,
  output tlb_ent_t [WAYS-1:0]    lk_ents
);
  localparam int N_ENT = LINES * WAYS;

  tlb_ent_t [N_ENT-1:0] ent_all;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      localparam tlb_ent_t RST_ENT = '{vpn: VOID_BASE | VPN_W'(l),
                                       pid: '0, pfn: '0, flg: '0};
      tlb_ent_t q;
      tlb_ent_t d;
      logic     en;

      always_comb begin
        en = wr_en && (wr_line == IDX_W'(l)) && (wr_way == WAY_W'(w));
        d  = wr_ent;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= RST_ENT;
        end else if (en) begin
          q <= d;
        end
      end

      assign ent_all[l*WAYS + w] = q;
    end
  end

  assign rd_ent = ent_all[{rd_line, rd_way}];

  for (genvar w = 0; w < WAYS; w++) begin : g_lk
    assign lk_ents[w] = ent_all[{lk_line, WAY_W'(w)}];
  end
endmodule

// File: rtl/sa_tlb_match.sv
module sa_tlb_match
  import sa_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  tlb_ent_t [WAYS-1:0] ents,
  input  logic [VPN_W-1:0]    vpn,
  input  logic [PID_W-1:0]    pid,
  output logic                hit,
  output logic [WAY_W-1:0]    way,
  output tlb_ent_t            ent
);
  logic [WAYS-1:0] way_hit;
  logic            probe_ok;

  assign probe_ok = !vpn_void(vpn);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic tag_eq;
    logic id_ok;
    assign tag_eq     = (ents[w].vpn == vpn);
    assign id_ok      = (ents[w].pid == pid) || ents[w].flg[FL_GLOBAL];
    assign way_hit[w] = probe_ok && tag_eq && id_ok;
  end

  always_comb begin
    hit = |way_hit;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) way = WAY_W'(w);
    end
    ent = ents[way];
  end
endmodule

// File: rtl/sa_tlb_csr.sv
module sa_tlb_csr
  import sa_tlb_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wen,
  input  logic [1:0]         reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  input  tlb_ent_t           rd_ent,
  output logic [IDX_W-1:0]   rd_line,
  output logic [WAY_W-1:0]   rd_way,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_line,
  output logic [WAY_W-1:0]   wr_way,
  output tlb_ent_t           wr_ent,
  output logic [PID_W-1:0]   cur_pid,
  output logic [REG_W-1:0]   addr_q,
  output logic [REG_W-1:0]   misc_q,
  output logic [REG_W-1:0]   acc_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic              we_q, we_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [PID_W-1:0]  pid_q, pid_d;
  logic [PFN_W-1:0]  pfn_q, pfn_d;
  logic [FLAG_N-1:0] flg_q, flg_d;
  logic              reg_en;

  logic [PFN_W-1:0]  w_pfn;
  logic [FLAG_N-1:0] w_flg;
  logic [WAY_W-1:0]  w_way;
  logic [PID_W-1:0]  w_pid;
  logic [WAY_W-1:0]  way_next;
  logic              unused_wdata;

  assign w_pfn   = reg_wdata[PFN_W-1:0];
  assign w_flg   = reg_wdata[ACC_FLG_LSB +: FLAG_N];
  assign w_way   = reg_wdata[MSC_WAY_LSB +: WAY_W];
  assign w_pid   = reg_wdata[MSC_PID_LSB +: PID_W];
  assign unused_wdata = ^reg_wdata;

  assign way_next = (way_q == WAY_W'(WAYS - 1)) ? '0 : way_q + 1'b1;

  assign rd_line = vpn_q[IDX_W-1:0];
  assign rd_way  = w_way;
  assign wr_line = vpn_q[IDX_W-1:0];
  assign wr_way  = way_q;
  assign wr_en   = reg_wen && (sel == SEL_ACC) && we_q;
  assign wr_ent  = '{vpn: vpn_q, pid: pid_q, pfn: w_pfn, flg: w_flg};
  assign cur_pid = pid_q;
  assign reg_en  = reg_wen;

  always_comb begin
    vpn_d = vpn_q;
    we_d  = we_q;
    way_d = way_q;
    pid_d = pid_q;
    pfn_d = pfn_q;
    flg_d = flg_q;
    unique case (sel)
      SEL_ADDR: vpn_d = reg_wdata[ADR_VPN_LSB +: VPN_W];
      SEL_MISC: begin
        we_d  = reg_wdata[MSC_WE];
        way_d = w_way;
        if (reg_wdata[MSC_RD]) begin
          vpn_d = rd_ent.vpn;
          pid_d = rd_ent.pid;
          pfn_d = rd_ent.pfn;
          flg_d = rd_ent.flg;
        end else begin
          pid_d = w_pid;
        end
      end
      SEL_ACC: begin
        pfn_d = w_pfn;
        flg_d = w_flg;
        if (we_q) way_d = way_next;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= '0;
      we_q  <= 1'b0;
      way_q <= '0;
      pid_q <= '0;
      pfn_q <= '0;
      flg_q <= '0;
    end else if (reg_en) begin
      vpn_q <= vpn_d;
      we_q  <= we_d;
      way_q <= way_d;
      pid_q <= pid_d;
      pfn_q <= pfn_d;
      flg_q <= flg_d;
    end
  end

  always_comb begin
    addr_q = '0;
    addr_q[ADR_VPN_LSB +: VPN_W] = vpn_q;
    misc_q = '0;
    misc_q[MSC_WE] = we_q;
    misc_q[MSC_WAY_LSB +: WAY_W] = way_q;
    misc_q[MSC_PID_LSB +: PID_W] = pid_q;
    acc_q = '0;
    acc_q[PFN_W-1:0] = pfn_q;
    acc_q[ACC_FLG_LSB +: FLAG_N] = flg_q;
  end
endmodule

// File: rtl/sa_tlb.sv
module sa_tlb
  import sa_tlb_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [1:0]          reg_sel,
  input  logic [REG_W-1:0]    reg_wdata,
  input  logic [REG_W-1:0]    lk_vaddr,
  output logic [REG_W-1:0]    addr_q,
  output logic [REG_W-1:0]    misc_q,
  output logic [REG_W-1:0]    acc_q,
  output logic                lk_hit,
  output logic [WAY_W-1:0]    lk_way,
  output logic [PFN_W-1:0]    lk_pfn,
  output logic [FLAG_N-1:0]   lk_flags
);
  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  tlb_ent_t             rd_ent;
  logic [IDX_W-1:0]     rd_line;
  logic [WAY_W-1:0]     rd_way;
  logic                 wr_en;
  logic [IDX_W-1:0]     wr_line;
  logic [WAY_W-1:0]     wr_way;
  tlb_ent_t             wr_ent;
  logic [PID_W-1:0]     cur_pid;
  tlb_ent_t [WAYS-1:0]  lk_ents;
  tlb_ent_t             hit_ent;
  logic [VPN_W-1:0]     lk_vpn;
  logic [IDX_W-1:0]     lk_line;
  logic                 unused_lk;

  assign lk_vpn    = lk_vaddr[PG_SHIFT +: VPN_W];
  assign lk_line   = lk_vpn[IDX_W-1:0];
  assign unused_lk = ^lk_vaddr[PG_SHIFT-1:0];

  sa_tlb_csr #(.LINES(LINES), .WAYS(WAYS)) u_csr (
    .clk(clk), .rst_n(rst_s2),
    .reg_wen(reg_wen), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_ent(rd_ent), .rd_line(rd_line), .rd_way(rd_way),
    .wr_en(wr_en), .wr_line(wr_line), .wr_way(wr_way), .wr_ent(wr_ent),
    .cur_pid(cur_pid),
    .addr_q(addr_q), .misc_q(misc_q), .acc_q(acc_q)
  );

  sa_tlb_store #(.LINES(LINES), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_s2),
    .wr_en(wr_en), .wr_line(wr_line), .wr_way(wr_way), .wr_ent(wr_ent),
    .rd_line(rd_line), .rd_way(rd_way), .rd_ent(rd_ent),
    .lk_line(lk_line), .lk_ents(lk_ents)
  );

  sa_tlb_match #(.WAYS(WAYS)) u_match (
    .ents(lk_ents), .vpn(lk_vpn), .pid(cur_pid),
    .hit(lk_hit), .way(lk_way), .ent(hit_ent)
  );

  assign lk_pfn   = hit_ent.pfn;
  assign lk_flags = hit_ent.flg;
endmodule

// File: rtl/sa_tlb_chk.sv
module sa_tlb_chk
  import sa_tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wen,
  input logic [1:0]       reg_sel,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] addr_q,
  input logic [REG_W-1:0] misc_q,
  input logic [REG_W-1:0] acc_q,
  input logic [REG_W-1:0] lk_vaddr,
  input logic             lk_hit
);
  // R2: page-address register has nothing outside the page-number field
  p_addr_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q[1:0] == 2'b00) && (addr_q[REG_W-1:ADR_VPN_LSB+VPN_W] == '0));

  // R3: read strobe never stays visible
  p_rd_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    misc_q[MSC_RD] == 1'b0);

  // R5: access register takes the written frame and flags
  p_acc_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_sel == 2'd2) |=> (acc_q == ($past(reg_wdata) & 32'h01FF_FFFF)));

  // R6: way advances and wraps after an enabled access write
  p_way_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_sel == 2'd2 && misc_q[MSC_WE]) |=>
      (misc_q[MSC_WAY_LSB +: WW] ==
        (($past(misc_q[MSC_WAY_LSB +: WW]) == WW'(WAYS - 1)) ? WW'(0)
          : WW'($past(misc_q[MSC_WAY_LSB +: WW]) + 1'b1))));

  // R6: without write enable the control register is untouched
  p_way_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_sel == 2'd2 && !misc_q[MSC_WE]) |=> $stable(misc_q));

  // R10: unmatchable page numbers never hit
  p_void_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vaddr[REG_W-1 -: 2] == VOID_TOP) |-> !lk_hit);
endmodule

bind sa_tlb sa_tlb_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/sim_sa_tlb.sv
module sim_sa_tlb;
  localparam int LINES = 16;
  localparam int WAYS  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wen;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] lk_vaddr;
  logic [31:0] addr_q, misc_q, acc_q;
  logic        lk_hit;
  logic [1:0]  lk_way;
  logic [19:0] lk_pfn;
  logic [4:0]  lk_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sa_tlb #(.LINES(LINES), .WAYS(WAYS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .lk_vaddr(lk_vaddr),
    .addr_q(addr_q), .misc_q(misc_q), .acc_q(acc_q),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_pfn(lk_pfn), .lk_flags(lk_flags)
  );

  localparam logic [7:0] P = 8'h21;

  function automatic logic [19:0] vpn_of(int l, int w);
    return 20'(((w * 5 + 1) << 4) | l);
  endfunction
  function automatic logic [19:0] pfn_of(int l, int w);
    return 20'h80000 | 20'((l << 4) | w);
  endfunction
  function automatic logic [4:0] flg_of(int l, int w);
    return 5'((l + w) & 15);
  endfunction
  function automatic logic [31:0] accw(logic [4:0] f, logic [19:0] p);
    return {7'b0, f, p};
  endfunction
  function automatic logic [31:0] miscw(logic [7:0] pid, int way, bit we, bit rd);
    return (32'(pid) << 16) | 32'((way & 3) << 4) | (we ? 32'h2 : 32'h0) | (rd ? 32'h1 : 32'h0);
  endfunction
  function automatic logic [31:0] hitv(int w, logic [4:0] f, logic [19:0] p);
    return {4'b0, 1'b1, 2'(w), f, p};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
  endtask

  task automatic look(input logic [31:0] va, output logic [31:0] res);
    lk_vaddr = va;
    #1;
    res = {4'b0, lk_hit, lk_way, lk_flags, lk_pfn};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [19:0] dv;
    rst_n = 1'b0; reg_wen = 1'b0; reg_sel = 2'd3; reg_wdata = '0; lk_vaddr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 addr", addr_q, 32'h0);
    chk("R1 misc", misc_q, 32'h0);
    chk("R1 acc", acc_q, 32'h0);
    for (int l = 0; l < LINES; l++) begin
      look({vpn_of(l, 0), 12'h0}, r);
      chk("R1 miss", 32'(r[27]), 32'h0);
      look({20'hC0000 | 20'(l), 12'h0}, r);
      chk("R1 void miss", 32'(r[27]), 32'h0);
    end

    // R2 / R3: register formats
    wr(2'd0, 32'hFFFF_FFFF);
    chk("R2 addr fmt", addr_q, 32'h003F_FFFC);
    wr(2'd1, 32'hFFFF_FFFE);
    chk("R3 misc fmt", misc_q, 32'h00FF_0032);

    // R5 / R6: fill every entry with auto-advancing way
    wr(2'd1, miscw(P, 0, 1, 0));
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WAYS; w++) begin
        wr(2'd0, {10'b0, vpn_of(l, w), 2'b0});
        wr(2'd2, accw(flg_of(l, w), pfn_of(l, w)));
        chk("R6 way advance", misc_q, miscw(P, (w + 1) % WAYS, 1, 0));
        chk("R5 acc", acc_q, accw(flg_of(l, w), pfn_of(l, w)));
      end
    end

    // R4: read back every entry
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WAYS; w++) begin
        wr(2'd0, {10'b0, vpn_of(l, 0), 2'b0});
        wr(2'd1, miscw(8'h00, w, 0, 1));
        chk("R4 addr", addr_q, {10'b0, vpn_of(l, w), 2'b0});
        chk("R4 misc", misc_q, miscw(P, w, 0, 0));
        chk("R4 acc", acc_q, accw(flg_of(l, w), pfn_of(l, w)));
      end
    end

    // R7: lookups with the owning identifier
    wr(2'd1, miscw(P, 0, 0, 0));
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WAYS; w++) begin
        look({vpn_of(l, w), 12'hABC}, r);
        chk("R7 hit", r, hitv(w, flg_of(l, w), pfn_of(l, w)));
      end
      look({20'(((2 << 4) | l)), 12'h0}, r);
      chk("R7 tag miss", 32'(r[27]), 32'h0);
    end

    // R8: other identifier misses
    wr(2'd1, miscw(8'h22, 0, 0, 0));
    for (int w = 0; w < WAYS; w++) begin
      look({vpn_of(9, w), 12'h0}, r);
      chk("R8 pid miss", 32'(r[27]), 32'h0);
    end

    // R7: global entry hits under any identifier
    wr(2'd1, miscw(8'h55, 2, 1, 0));
    wr(2'd0, {10'b0, vpn_of(3, 2), 2'b0});
    wr(2'd2, accw(5'h13, 20'h0CAFE));
    wr(2'd1, miscw(P, 0, 0, 0));
    look({vpn_of(3, 2), 12'h0}, r);
    chk("R7 global hit", r, hitv(2, 5'h13, 20'h0CAFE));
    wr(2'd1, miscw(8'h99, 0, 0, 0));
    look({vpn_of(3, 2), 12'h0}, r);
    chk("R7 global other pid", r, hitv(2, 5'h13, 20'h0CAFE));

    // R9: duplicate page in line 5, higher way written first
    dv = 20'((9 << 4) | 5);
    wr(2'd1, miscw(P, 3, 1, 0));
    wr(2'd0, {10'b0, dv, 2'b0});
    wr(2'd2, accw(5'h02, 20'h11111));
    chk("R6 wrap", misc_q, miscw(P, 0, 1, 0));
    wr(2'd1, miscw(P, 1, 1, 0));
    wr(2'd2, accw(5'h04, 20'h22222));
    look({dv, 12'h0}, r);
    chk("R9 lowest way", r, hitv(1, 5'h04, 20'h22222));

    // R10: invalidate way 1, then way 3
    wr(2'd1, miscw(P, 1, 1, 0));
    wr(2'd0, {10'b0, 20'hC0005, 2'b0});
    wr(2'd2, 32'h0);
    look({dv, 12'h0}, r);
    chk("R10 survivor", r, hitv(3, 5'h02, 20'h11111));
    wr(2'd1, miscw(P, 3, 1, 0));
    wr(2'd2, 32'h0);
    look({dv, 12'h0}, r);
    chk("R10 removed", 32'(r[27]), 32'h0);
    look({20'hC0005, 12'h0}, r);
    chk("R10 void stored", 32'(r[27]), 32'h0);

    // R6: access write without write enable
    wr(2'd1, miscw(P, 2, 0, 0));
    wr(2'd0, {10'b0, vpn_of(6, 2), 2'b0});
    wr(2'd2, accw(5'h1F, 20'h0BEEF));
    chk("R6 no-we way", misc_q, miscw(P, 2, 0, 0));
    chk("R5 no-we acc", acc_q, accw(5'h1F, 20'h0BEEF));
    look({vpn_of(6, 2), 12'h0}, r);
    chk("R6 no-we entry", r, hitv(2, flg_of(6, 2), pfn_of(6, 2)));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule